// File: doc/BRIEF.md
# Stepper Phase Driver Programming Front End

This block is the digital front end of a unipolar stepper phase driver. It watches four phase request inputs and two data/control inputs, all asynchronous to its clock. When every phase input is low the block is in programming mode: once that all-low condition has lasted a qualification time, one configuration bit is shifted into a 6-bit register. The bit is the exclusive-OR of the two data/control pins. Any other phase pattern puts the block in operating mode, where the same pins are decoded into phase-on requests, a loop-mode select and a reduced-current request.

Two variants are chosen by a parameter. In the full variant each of the four phase inputs drives its own phase, and the stored word selects the open-loop duty cycle and the closed-loop chopping rate for downstream logic. In the simplified variant only the first two phase inputs drive phases, the third acts as an enable, and the fourth together with the level pin requests the reduced current. That variant needs no prior programming. The power stage, the current-sense comparator, the oscillator and the chopper are outside this block.

Top module: `stepdrv_front`

## Requirements
- R1: While `rst` is high at a clock edge, `ph_on`, `open_loop` and `reduce_lvl` are 0 after that edge, and so is `cfg_word`.
- R2: Every input passes through a `SYNC_STAGES`-flop synchroniser (default 2) and then through one output register. A change at the inputs reaches `ph_on`, `open_loop` and `reduce_lvl` after the third rising edge.
- R3: Programming mode holds when all four synchronised bits of `ph_in` are 0. During it `ph_on`, `open_loop` and `reduce_lvl` are driven to 0.
- R4: A shift happens only on the clock edge at which the synchronised all-low condition has been seen on `QUAL_CYC` consecutive edges. An all-low run of fewer than `QUAL_CYC` edges leaves `cfg_word` unchanged.
- R5: Each all-low run gives at most one shift, however long it lasts. A new shift needs a return to operating mode and a new qualified run.
- R6: The shifted bit is `dat_lev XOR dat_loop`, synchronised. The word shifts toward the MSB and the new bit enters at bit 0, so the first bit of a 6-bit sequence ends in bit 5.
- R7: In operating mode `open_loop` equals the synchronised `dat_loop`: 1 selects open-loop current control and 0 selects closed-loop current control.
- R8: Full variant (`MODE` = `MODE_FULL`): in operating mode `ph_on[i]` equals the synchronised `ph_in[i]` for i = 0..3, and `reduce_lvl` equals the synchronised `dat_lev`.
- R9: Simplified variant (`MODE` = `MODE_SIMPLE`): in operating mode `ph_on[0]` = `ph_in[0] & ph_in[2]`, `ph_on[1]` = `ph_in[1] & ph_in[2]`, `ph_on[3:2]` = 0, and `reduce_lvl` = `ph_in[3] & dat_lev`, all from synchronised values.
- R10: `cfg_word` changes only on a shift edge. It holds its value through any length of operating mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_in | input | 4 | Asynchronous phase requests; bit i is phase i+1 |
| dat_lev | input | 1 | Serial data term in programming mode; current-level request in operating mode |
| dat_loop | input | 1 | Serial data term in programming mode; loop-mode select in operating mode |
| ph_on | output | 4 | Registered phase-on requests |
| open_loop | output | 1 | 1 for open-loop current control, 0 for closed-loop current control |
| reduce_lvl | output | 1 | Reduced-current request |
| cfg_word | output | CFG_W | Stored configuration word |

## Verification
The bench builds two copies of the block side by side on the same inputs: one with `MODE_FULL` and one with `MODE_SIMPLE`. Both use `QUAL_CYC` = 4 in place of the 25 cycles that 0.2 µs takes at 125 MHz. With that short window, runs of exactly `QUAL_CYC`-1 and `QUAL_CYC` low edges are cheap to produce, as are very long runs and many random all-low intervals. The default two synchroniser stages keep the three-edge latency that the reference model encodes.

// File: rtl/stepdrv_pkg.sv
package stepdrv_pkg;

    localparam int PHASES = 4;

    typedef enum logic {
        MODE_FULL   = 1'b0,
        MODE_SIMPLE = 1'b1
    } drv_mode_e;

    // synchronised view of the input pins
    typedef struct packed {
        logic [PHASES-1:0] ph;
        logic              dat_lev;
        logic              dat_loop;
    } pins_t;

    // registered drive requests
    typedef struct packed {
        logic [PHASES-1:0] ph_on;
        logic              open_loop;
        logic              reduce;
    } drive_t;

    function automatic logic is_prog(pins_t p);
        return (p.ph == '0);
    endfunction

    function automatic logic serial_bit(pins_t p);
        return p.dat_lev ^ p.dat_loop;
    endfunction

    function automatic drive_t decode_full(pins_t p);
        drive_t d;
        d.ph_on     = p.ph;
        d.open_loop = p.dat_loop;
        d.reduce    = p.dat_lev;
        return d;
    endfunction

    function automatic drive_t decode_simple(pins_t p);
        drive_t d;
        d.ph_on     = '0;
        d.ph_on[0]  = p.ph[0] & p.ph[2];
        d.ph_on[1]  = p.ph[1] & p.ph[2];
        d.open_loop = p.dat_loop;
        d.reduce    = p.ph[3] & p.dat_lev;
        return d;
    endfunction

endpackage

// File: rtl/stepdrv_sync.sv
module stepdrv_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/stepdrv_qual.sv
module stepdrv_qual #(
    parameter int QUAL_CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic all_low,
    output logic shift_p
);
    localparam int CW = $clog2(QUAL_CYC + 1);

    logic [CW-1:0] low_cnt;

    // counts all-low edges, saturating so that one run yields one pulse
    always_ff @(posedge clk) begin
        if (rst || !all_low) begin
            low_cnt <= '0;
        end else if (low_cnt != CW'(QUAL_CYC)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign shift_p = all_low && (low_cnt == CW'(QUAL_CYC - 1));
endmodule

// File: rtl/stepdrv_cfgreg.sv
module stepdrv_cfgreg #(
    parameter int CFG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [CFG_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[CFG_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/stepdrv_decode.sv
module stepdrv_decode
    import stepdrv_pkg::*;
#(
    parameter drv_mode_e MODE = MODE_FULL
) (
    input  logic   clk,
    input  logic   rst,
    input  pins_t  s,
    input  logic   prog,
    output drive_t q
);
    drive_t nxt;

    generate
        if (MODE == MODE_SIMPLE) begin : g_simple
            assign nxt = decode_simple(s);
        end else begin : g_full
            assign nxt = decode_full(s);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || prog) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/stepdrv_front.sv
module stepdrv_front
    import stepdrv_pkg::*;
#(
    parameter int        QUAL_CYC    = 25,
    parameter int        CFG_W       = 6,
    parameter int        SYNC_STAGES = 2,
    parameter drv_mode_e MODE        = MODE_FULL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       ph_in,
    input  logic             dat_lev,
    input  logic             dat_loop,
    output logic [3:0]       ph_on,
    output logic             open_loop,
    output logic             reduce_lvl,
    output logic [CFG_W-1:0] cfg_word
);
    localparam int PW = $bits(pins_t);

    pins_t          raw;
    logic [PW-1:0]  s_vec;
    pins_t          s_pins;
    logic           all_low;
    logic           shift_p;
    drive_t         drv;

    assign raw.ph       = ph_in;
    assign raw.dat_lev  = dat_lev;
    assign raw.dat_loop = dat_loop;

    stepdrv_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (s_vec)
    );

    assign s_pins  = pins_t'(s_vec);
    assign all_low = is_prog(s_pins);

    stepdrv_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .all_low (all_low),
        .shift_p (shift_p)
    );

    stepdrv_cfgreg #(.CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_p),
        .bit_in   (serial_bit(s_pins)),
        .word     (cfg_word)
    );

    stepdrv_decode #(.MODE(MODE)) u_dec (
        .clk  (clk),
        .rst  (rst),
        .s    (s_pins),
        .prog (all_low),
        .q    (drv)
    );

    assign ph_on      = drv.ph_on;
    assign open_loop  = drv.open_loop;
    assign reduce_lvl = drv.reduce;
endmodule

// File: rtl/stepdrv_front_chk.sv
module stepdrv_front_chk
    import stepdrv_pkg::*;
#(
    parameter int        QUAL_CYC = 25,
    parameter int        CFG_W    = 6,
    parameter drv_mode_e MODE     = MODE_FULL
) (
    input logic             clk,
    input logic             rst,
    input logic             all_low,
    input logic             shift_p,
    input pins_t            sync_pins,
    input logic [3:0]       ph_on,
    input logic             open_loop,
    input logic             reduce_lvl,
    input logic [CFG_W-1:0] cfg_word
);
    localparam int CW = $clog2(QUAL_CYC + 1);

    logic [CW-1:0] run;
    logic          done;

    always_ff @(posedge clk) begin
        if (rst || !all_low) begin
            run  <= '0;
            done <= 1'b0;
        end else begin
            if (run != CW'(QUAL_CYC)) run <= run + 1'b1;
            if (shift_p) done <= 1'b1;
        end
    end

    assert_shift_after_qual_R4: assert property (@(posedge clk) disable iff (rst)
        shift_p |-> (all_low && run == CW'(QUAL_CYC - 1)));

    assert_single_shift_R5: assert property (@(posedge clk) disable iff (rst)
        shift_p |-> !done);

    assert_cfg_only_on_shift_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_word) |-> $past(shift_p));

    assert_idle_in_prog_R3: assert property (@(posedge clk) disable iff (rst)
        $past(all_low) |-> (ph_on == 4'b0 && !open_loop && !reduce_lvl));

    assert_loop_select_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(all_low) |-> (open_loop == $past(sync_pins.dat_loop)));

    assert_simple_upper_off_R9: assert property (@(posedge clk) disable iff (rst)
        (MODE == MODE_SIMPLE) |-> (ph_on[3:2] == 2'b00));
endmodule

bind stepdrv_front stepdrv_front_chk #(
    .QUAL_CYC (QUAL_CYC),
    .CFG_W    (CFG_W),
    .MODE     (MODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .all_low    (all_low),
    .shift_p    (shift_p),
    .sync_pins  (s_pins),
    .ph_on      (ph_on),
    .open_loop  (open_loop),
    .reduce_lvl (reduce_lvl),
    .cfg_word   (cfg_word)
);

// File: tb/sim_stepdrv_front.sv
`timescale 1ns/1ps
module sim_stepdrv_front;
    import stepdrv_pkg::*;

    localparam int QUAL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ph_in = 4'b0001;
    logic       dat_lev = 1'b0;
    logic       dat_loop = 1'b0;

    logic [3:0] f_ph, s_ph;
    logic       f_ol, s_ol, f_rd, s_rd;
    logic [5:0] f_cfg, s_cfg;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    stepdrv_front #(.QUAL_CYC(QUAL), .MODE(MODE_FULL)) u0 (
        .clk(clk), .rst(rst), .ph_in(ph_in), .dat_lev(dat_lev), .dat_loop(dat_loop),
        .ph_on(f_ph), .open_loop(f_ol), .reduce_lvl(f_rd), .cfg_word(f_cfg));

    stepdrv_front #(.QUAL_CYC(QUAL), .MODE(MODE_SIMPLE)) u1 (
        .clk(clk), .rst(rst), .ph_in(ph_in), .dat_lev(dat_lev), .dat_loop(dat_loop),
        .ph_on(s_ph), .open_loop(s_ol), .reduce_lvl(s_rd), .cfg_word(s_cfg));

    // reference model: pin history two edges deep, run length of low phases
    logic [5:0] hist [$];
    int         run;
    logic [5:0] e_cfg;
    logic [3:0] e_fph, e_sph;
    logic       e_ol, e_frd, e_srd;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{6'h0, 6'h0};
            run = 0; e_cfg = '0;
            e_fph = '0; e_sph = '0; e_ol = 0; e_frd = 0; e_srd = 0;
        end else begin
            logic [5:0] p;
            p = hist.pop_front();
            if (p[5:2] == 4'b0) begin
                e_fph = '0; e_sph = '0; e_ol = 0; e_frd = 0; e_srd = 0;
                run++;
                if (run == QUAL) e_cfg = {e_cfg[4:0], p[1] ^ p[0]};
            end else begin
                run = 0;
                e_fph = p[5:2];
                e_ol  = p[0];
                e_frd = p[1];
                e_sph = {2'b00, p[3] & p[4], p[2] & p[4]};
                e_srd = p[5] & p[1];
            end
            hist.push_back({ph_in, dat_lev, dat_loop});
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(f_ph == e_fph, "R8 full ph_on", f_ph, e_fph);
            check(f_rd == e_frd, "R8 full reduce_lvl", f_rd, e_frd);
            check(f_ol == e_ol,  "R7 full open_loop", f_ol, e_ol);
            check(s_ol == e_ol,  "R7 simple open_loop", s_ol, e_ol);
            check(s_ph == e_sph, "R9 simple ph_on", s_ph, e_sph);
            check(s_rd == e_srd, "R9 simple reduce_lvl", s_rd, e_srd);
            check(f_cfg == e_cfg, "R6 full cfg_word", f_cfg, e_cfg);
            check(s_cfg == e_cfg, "R6 simple cfg_word", s_cfg, e_cfg);
        end
    end

    // called at a falling edge; holds the values for n rising edges
    task automatic drive(input logic [3:0] ph, input logic lev, input logic lp, input int n);
        ph_in = ph; dat_lev = lev; dat_loop = lp;
        repeat (n) @(negedge clk);
    endtask

    task automatic prog_bit(input logic lev, input logic lp, input int n);
        drive(4'b0000, lev, lp, n);
        drive(4'b1000, lev, lp, 3);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is still applied
        check(f_ph == 0 && !f_ol && !f_rd, "R1 full outputs", {f_ph, f_ol, f_rd}, 0);
        check(s_ph == 0 && !s_ol && !s_rd, "R1 simple outputs", {s_ph, s_ol, s_rd}, 0);
        check(f_cfg == 0 && s_cfg == 0, "R1 cfg_word", f_cfg, 0);
        rst = 1'b0;
        cmp_on = 1;
        drive(4'b1100, 0, 0, 6);

        // R2 latency: three rising edges from pins to outputs
        ph_in = 4'b0011; dat_loop = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(f_ph == 4'b1100, "R2 before third edge", f_ph, 4'b1100);
        @(negedge clk);
        check(f_ph == 4'b0011 && f_ol, "R2 after third edge", {f_ph, f_ol}, 5'b00111);
        drive(4'b0011, 0, 1, 3);

        // R4 a run one edge short of the window shifts nothing
        prog_bit(1, 0, QUAL - 1);
        check(f_cfg == 6'b0, "R4 short run", f_cfg, 0);

        // R3 programming mode idles the outputs
        drive(4'b0000, 1, 1, 3);
        check(f_ph == 0 && !f_ol && !f_rd, "R3 idle in prog", {f_ph, f_ol, f_rd}, 0);

        // R5 a long run shifts exactly once (lev^loop = 1)
        drive(4'b0000, 1, 0, 30);
        drive(4'b1000, 1, 0, 3);
        check(f_cfg == 6'b000001, "R5 one shift per run", f_cfg, 6'b000001);

        // R6 six bits, MSB first, XOR of the two data pins: 1 0 1 1 0 1
        prog_bit(1, 0, QUAL);
        prog_bit(1, 1, QUAL + 2);
        prog_bit(0, 1, QUAL);
        prog_bit(1, 0, QUAL + 5);
        prog_bit(0, 0, QUAL);
        prog_bit(0, 1, QUAL + 1);
        check(f_cfg == 6'b101101, "R6 full word", f_cfg, 6'b101101);
        check(s_cfg == 6'b101101, "R6 simple word", s_cfg, 6'b101101);

        // R10 operating traffic leaves the word alone
        for (int i = 0; i < 40; i++) drive(4'(i % 15 + 1), i[0], i[1], 1);
        drive(4'b0110, 0, 0, 3);
        check(f_cfg == 6'b101101, "R10 word held", f_cfg, 6'b101101);

        // R9 enable low blocks both phases; upper inputs ignored
        drive(4'b1011, 1, 0, 4);
        check(s_ph == 4'b0000 && s_rd, "R9 enable off", {s_ph, s_rd}, 5'b00001);
        drive(4'b0101, 1, 0, 4);
        check(s_ph == 4'b0001 && !s_rd, "R9 enable on", {s_ph, s_rd}, 5'b00010);
        // R8 full variant passes each phase through
        check(f_ph == 4'b0101 && f_rd, "R8 full pass", {f_ph, f_rd}, 5'b01011);

        // random mix with frequent all-low runs of varied length
        for (int i = 0; i < 600; i++) begin
            logic [3:0] ph;
            ph = ($urandom % 3 == 0) ? 4'b0 : 4'($urandom);
            drive(ph, 1'($urandom), 1'($urandom), 1 + ($urandom % 7));
        end

        cmp_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule